// File: doc/BRIEF.md
# Smoothed Stereo Digital Attenuator

This block scales two signed 16-bit sample streams, left and right, by an 8-bit linear gain code each. A code of 0xFF passes samples unchanged, 0x00 silences the channel, and every code in between scales by code/255. Gain changes never take effect at once. Each channel keeps a present gain that walks one code step toward its commanded target every fourth sample strobe. A full sweep from unity to silence therefore takes 1020 sample periods.

A controller loads both target codes and a share flag with a single write strobe. When the share flag is set, the right channel follows the left target, so one code drives both sides. A new target may be written while a glide is still running. The present gain then turns toward the new value from wherever it stands, without restarting.

Samples arrive with a strobe. The scaled pair appears one clock later, together with a one-cycle valid pulse.

Top module: `stereo_gain_glide`

## Requirements
- R1: After reset both targets and both present gains are 0xFF, the share flag is clear, `out_valid` is low and both outputs are zero. A sample sent before any code write comes out unchanged.
- R2: Each output equals sample × gain / 255, rounded to nearest with ties away from zero, and saturated to the signed 16-bit range. The gain used is the channel's present gain in the strobe cycle, taken before any step made at that strobe.
- R3: While a channel's present gain is 0, its output is exactly zero for every input sample, including -32768.
- R4: When the share flag is loaded as 1, the right channel's target is the left target code and the right code is ignored. Loading the flag as 0 restores the right code.
- R5: Strobes are counted from reset, modulo 4. On every fourth strobe each present gain moves exactly one code toward its target. A sweep from 0xFF to 0x00 is therefore complete after 1020 strobes.
- R6: A present gain stops exactly on its target and never passes it. While it equals its target it does not change.
- R7: A target written during a glide redirects the present gain from its current value toward the new target, and the glide does not restart from the previous target.
- R8: `out_valid` is high for exactly the one cycle that follows each cycle with `smp_valid` high, and low otherwise. New targets written with `code_we` are used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_we | input | 1 | Loads both target codes and the share flag |
| code_l | input | 8 | Left target code |
| code_r | input | 8 | Right target code |
| share_left | input | 1 | When loaded as 1, the right channel follows the left code |
| smp_valid | input | 1 | Sample strobe |
| smp_l | input | 16 | Left sample, two's complement |
| smp_r | input | 16 | Right sample, two's complement |
| out_valid | output | 1 | Scaled pair valid, one cycle after the strobe |
| out_l | output | 16 | Scaled left sample |
| out_r | output | 16 | Scaled right sample |

## Verification
The assertions assume that targets only change through `code_we`, and that `smp_valid` is a single-cycle strobe, so that every step can be tied to one strobe. The stimulus never raises `code_we` in the same cycle as `smp_valid`, and it leaves idle cycles between strobes. Under these conditions the bench's gain model changes state in the same order as the design. The glides are long enough to reach every step boundary, including a redirect in mid-glide, a full sweep to silence, and samples at both extremes of the 16-bit range.

// File: rtl/stereo_gain_glide.sv
module stereo_gain_glide #(
  parameter int DW = 16,
  parameter int GW = 8,
  parameter int STEP_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_we,
  input  logic [GW-1:0] code_l,
  input  logic [GW-1:0] code_r,
  input  logic          share_left,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_l,
  input  logic [DW-1:0] smp_r,
  output logic          out_valid,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r
);
  localparam int PW = DW + GW + 1;
  localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [GW-1:0] tgt_l, tgt_r, cur_l, cur_r;
  logic          share_q;
  logic [CW-1:0] div_q;
  logic [GW-1:0] eff_l, eff_r;
  logic          step_now;

  assign eff_l    = tgt_l;
  assign eff_r    = share_q ? tgt_l : tgt_r;
  assign step_now = smp_valid && (div_q == CW'(STEP_DIV - 1));

  function automatic logic [GW-1:0] glide(input logic [GW-1:0] c, input logic [GW-1:0] t);
    if (c < t)      return c + 1'b1;
    else if (c > t) return c - 1'b1;
    else            return c;
  endfunction

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] s, input logic [GW-1:0] g);
    logic signed [PW-1:0] p;
    logic [PW-1:0]        mag, q;
    logic signed [PW-1:0] r;
    p   = $signed({{(PW-DW){s[DW-1]}}, s}) * $signed({{(PW-GW){1'b0}}, g});
    mag = p[PW-1] ? PW'(-p) : PW'(p);
    q   = (mag + PW'(GMAX / 2)) / PW'(GMAX);
    r   = p[PW-1] ? -$signed(q) : $signed(q);
    if (g == '0)
      return '0;
    if (r > $signed(PW'((1 << (DW-1)) - 1)))
      return {1'b0, {(DW-1){1'b1}}};
    if (r < -$signed(PW'(1 << (DW-1))))
      return {1'b1, {(DW-1){1'b0}}};
    return r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_l   <= GMAX;
      tgt_r   <= GMAX;
      share_q <= 1'b0;
    end else if (code_we) begin
      tgt_l   <= code_l;
      tgt_r   <= code_r;
      share_q <= share_left;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_l <= GMAX;
      cur_r <= GMAX;
      div_q <= '0;
    end else begin
      if (smp_valid)
        div_q <= (div_q == CW'(STEP_DIV - 1)) ? '0 : div_q + 1'b1;
      if (step_now) begin
        cur_l <= glide(cur_l, eff_l);
        cur_r <= glide(cur_r, eff_r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        out_l <= scale(smp_l, cur_l);
        out_r <= scale(smp_r, cur_r);
      end
    end
  end
endmodule

module gain_glide_props #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r,
  input logic [GW-1:0] cur_l,
  input logic [GW-1:0] cur_r,
  input logic [GW-1:0] eff_l,
  input logic [GW-1:0] eff_r
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  p_valid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  p_mute_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cur_l == '0) |=> out_l == '0);
  p_mute_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cur_r == '0) |=> out_r == '0);
  p_one_step_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_l == $past(cur_l)) || (cur_l == $past(cur_l) + 1'b1) || (cur_l == $past(cur_l) - 1'b1));
  p_one_step_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_r == $past(cur_r)) || (cur_r == $past(cur_r) + 1'b1) || (cur_r == $past(cur_r) - 1'b1));
  p_hold_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_l == eff_l) |=> $stable(cur_l));
  p_hold_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_r == eff_r) |=> $stable(cur_r));
  p_no_overshoot_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_l < eff_l) |=> cur_l <= $past(eff_l));
  p_no_overshoot_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_l > eff_l) |=> cur_l >= $past(eff_l));
endmodule

bind stereo_gain_glide gain_glide_props #(.DW(DW), .GW(GW)) u_props (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .out_valid(out_valid),
  .out_l(out_l), .out_r(out_r), .cur_l(cur_l), .cur_r(cur_r),
  .eff_l(eff_l), .eff_r(eff_r)
);

// File: tb/tb_stereo_gain_glide.sv
module tb_stereo_gain_glide;
  logic clk = 0, rst_n = 0;
  logic code_we = 0, share_left = 0, smp_valid = 0;
  logic [7:0] code_l = 0, code_r = 0;
  logic [15:0] smp_l = 0, smp_r = 0;
  logic out_valid;
  logic [15:0] out_l, out_r;

  always #4 clk = ~clk;

  stereo_gain_glide dut (.*);

  int compared = 0, mismatched = 0;
  int g_l = 255, g_r = 255, t_l = 255, t_r = 255, strobes = 0;
  bit m_share = 0, done = 0;
  logic [15:0] q_l[$], q_r[$];
  string q_tag[$];

  function automatic logic [15:0] expect_scale(logic [15:0] s, int g);
    int p, a, q;
    p = $signed(s) * g;
    a = (p < 0) ? -p : p;
    q = (a + 127) / 255;
    if (p < 0) q = -q;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q[15:0];
  endfunction

  function automatic int toward(int c, int t);
    return (c < t) ? c + 1 : (c > t) ? c - 1 : c;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_codes(int l, int r, bit sh);
    @(negedge clk);
    code_we = 1; code_l = l[7:0]; code_r = r[7:0]; share_left = sh;
    @(negedge clk);
    code_we = 0;
    t_l = l; t_r = r; m_share = sh;
  endtask

  task automatic send(logic [15:0] sl, logic [15:0] sr, string tag);
    int er;
    @(negedge clk);
    smp_valid = 1; smp_l = sl; smp_r = sr;
    q_l.push_back(expect_scale(sl, g_l));
    q_r.push_back(expect_scale(sr, g_r));
    q_tag.push_back(tag);
    strobes++;
    if (strobes % 4 == 0) begin
      er = m_share ? t_l : t_r;
      g_l = toward(g_l, t_l);
      g_r = toward(g_r, er);
    end
    @(negedge clk);
    smp_valid = 0;
  endtask

  function automatic logic [15:0] pat(int i);
    case (i % 5)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'(i * 7919);
      3: return 16'(-i * 313);
      default: return 16'(i);
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_l.size() == 0) begin
        check(0, "R8", "unexpected out_valid", 1, 0);
      end else begin
        logic [15:0] el, er;
        string tg;
        el = q_l.pop_front(); er = q_r.pop_front(); tg = q_tag.pop_front();
        check(out_l == el, tg, "out_l", $signed(out_l), $signed(el));
        check(out_r == er, tg, "out_r", $signed(out_r), $signed(er));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(out_l == 0 && out_r == 0, "R1", "outputs after reset", out_l, 0);
    for (int i = 0; i < 6; i++) send(pat(i), pat(i + 2), "R1");
    @(negedge clk);
    check(out_valid == 0, "R8", "valid drops after strobe", out_valid, 0);

    set_codes(8'h80, 8'hFF, 0);
    for (int i = 0; i < 540; i++) send(pat(i), pat(i + 1), "R2");
    check(g_l == 128, "R6", "model left settles", g_l, 128);

    set_codes(8'h00, 8'h40, 0);
    for (int i = 0; i < 200; i++) send(pat(i), pat(i + 3), "R5");
    set_codes(8'hC0, 8'h40, 0);
    for (int i = 0; i < 300; i++) send(pat(i), pat(i + 4), "R7");

    set_codes(8'h20, 8'hFF, 1);
    for (int i = 0; i < 700; i++) send(pat(i), pat(i + 1), "R4");
    set_codes(8'h20, 8'hFF, 0);
    for (int i = 0; i < 60; i++) send(pat(i), pat(i + 2), "R4");

    set_codes(8'hFF, 8'hFF, 0);
    for (int i = 0; i < 1100; i++) send(pat(i), pat(i), "R6");
    set_codes(8'h00, 8'h00, 0);
    for (int i = 0; i < 1020; i++) send(pat(i), pat(i + 1), "R5");
    check(g_l == 0 && g_r == 0, "R5", "model full sweep", g_l, 0);
    for (int i = 0; i < 10; i++) send(16'h8000, 16'h7FFF, "R3");

    repeat (4) @(negedge clk);
    check(q_l.size() == 0, "R8", "pending results", q_l.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule